// File: doc/BRIEF.md
# Software Interrupt Source Tracker

This block turns software interrupt requests into per-target pending state. A CPU posts a request by writing a 32-bit trigger word. The word names one of sixteen software interrupt numbers and a rule for picking the target CPUs. For each target, the block keeps a small bitmap of which CPUs have posted that number to it. So one target can hold the same software interrupt from several sources at the same moment.

When a target acknowledges one of these interrupts, the block picks the lowest-numbered source still recorded and returns it next to the interrupt number. It then clears only that one source. The pending state for the target stays raised until every recorded source has been acknowledged or cleared.

Software can also reach each bitmap directly. A byte write can set source bits in, or clear them from, the writer's own bitmap for a chosen number, and a combinational read port shows that bitmap. Pending changes leave the block as one-cycle set and clear pulses. A neighbouring pending-state store consumes them. Choosing which interrupt to deliver belongs to a different block.

Top module: `sgi_dispatch`

## Requirements
- R1: In a trigger write, bits 9:0 carry the interrupt number and bits 25:24 carry the target rule. A number of 16 or more is dropped: it raises no `pend_set` bit and changes no bitmap.
- R2: Rule 0 takes the target list from trigger bits 23:16, where bit 16+n selects CPU n. List bits for CPUs at or above `N_CPU` are discarded.
- R3: Rule 1 selects every implemented CPU except the writer. Rule 2 selects only the writer. Rule 3 selects every implemented CPU.
- R4: For each selected target t, the writer's bit is set in t's bitmap for the number. `pend_set` bit t*16+number pulses for one cycle, in the cycle after the strobe.
- R5: An acknowledge from target t with a number below 16 reports the lowest set source bit of t's bitmap for that number and clears only that bit. `ack_val` slot t holds the number in bits 9:0 and the source index in bits 12:10. It is valid while `ack_vld[t]` pulses, in the cycle after `ack_req[t]`.
- R6: `pend_clr` bit t*16+number pulses for one cycle, in the cycle after a clearing operation on that bitmap, and only if the bitmap is then empty. A clearing operation is an acknowledge or a clear byte write.
- R7: A clear byte write (`src_set`=0) removes the `src_data` bits from the writer's bitmap for `src_id`.
- R8: A set byte write (`src_set`=1) ORs `src_data` into the writer's bitmap for `src_id`. It pulses the writer's `pend_set` bit even when `src_data` is zero.
- R9: `src_rdata` shows, combinationally, the bitmap of CPU `wr_cpu` for number `src_id`, zero-extended to 8 bits.
- R10: An acknowledge whose bitmap is empty, or whose number is 16 or more, returns the number with source 0. It changes no bitmap and raises no `pend_clr` bit.
- R11: After reset, every bitmap is empty and `pend_set`, `pend_clr`, `ack_vld` and `ack_val` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_we | input | 1 | Trigger word write strobe |
| trig_data | input | 32 | Trigger word |
| wr_cpu | input | 3 | Index of the CPU doing the trigger or byte access |
| src_we | input | 1 | Source byte write strobe |
| src_set | input | 1 | 1: byte write sets bits, 0: byte write clears bits |
| src_id | input | 4 | Interrupt number for byte access and read |
| src_data | input | 8 | Source bits for byte write |
| src_rdata | output | 8 | Bitmap of `wr_cpu` for `src_id` |
| ack_req | input | N_CPU | Per-target acknowledge request |
| ack_id | input | N_CPU*10 | Per-target acknowledged number, slot t at bits t*10 |
| ack_vld | output | N_CPU | Per-target acknowledge result valid |
| ack_val | output | N_CPU*13 | Per-target result {source, number}, slot t at bits t*13 |
| pend_set | output | N_CPU*16 | Pending set pulses, bit t*16+number |
| pend_clr | output | N_CPU*16 | Pending clear pulses, bit t*16+number |

## Verification
Each trigger, byte write and acknowledge updates the bitmaps on the clock edge that samples its strobe. The `pend_set`, `pend_clr`, `ack_vld` and `ack_val` results come from registers loaded on that same edge, so they are valid for exactly the following cycle. `src_rdata` follows the updated bitmap with no further delay. The bench drives every strobe on a falling edge and holds it across one rising edge. It checks the pulse outputs at the next falling edge, while they are still valid, and then reads the bitmaps back through `src_rdata` to confirm what each operation left behind.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
   localparam int SGI_NUM   = 16;
   localparam int SGI_IDX_W = 4;
   localparam int ID_W      = 10;
   localparam int SRC_W     = 3;
   localparam int ACK_W     = ID_W + SRC_W;
   localparam int CPU_W     = 3;
   localparam int MAX_CPU   = 8;

   typedef enum logic [1:0] {
      FLT_LIST   = 2'd0,
      FLT_OTHERS = 2'd1,
      FLT_SELF   = 2'd2,
      FLT_ALL    = 2'd3
   } flt_e;
endpackage

// File: rtl/sgi_target_decode.sv
module sgi_target_decode
   import sgi_pkg::*;
#(
   parameter int N_CPU = 4
) (
   input  logic [1:0]       flt,
   input  logic [7:0]       list,
   input  logic [N_CPU-1:0] wr_oh,
   output logic [N_CPU-1:0] tmask
);
   always_comb begin
      case (flt_e'(flt))
         FLT_LIST:   tmask = list[N_CPU-1:0];
         FLT_OTHERS: tmask = ~wr_oh;
         FLT_SELF:   tmask = wr_oh;
         default:    tmask = '1;
      endcase
   end
endmodule

// File: rtl/sgi_first_set.sv
module sgi_first_set #(
   parameter int W = 4,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic [W-1:0]     onehot,
   output logic [IDX_W-1:0] idx,
   output logic             any
);
   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end

   assign onehot = vec & (~vec + W'(1));
   assign any    = |vec;
endmodule

// File: rtl/sgi_src_cell.sv
module sgi_src_cell #(
   parameter int N_CPU = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CPU-1:0] set_bits,
   input  logic             set_hit,
   input  logic [N_CPU-1:0] clr_bits,
   input  logic             clr_hit,
   output logic [N_CPU-1:0] bmap,
   output logic             pset,
   output logic             pclr
);
   logic [N_CPU-1:0] bmap_nxt;

   assign bmap_nxt = (bmap & ~clr_bits) | set_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bmap <= '0;
         pset <= 1'b0;
         pclr <= 1'b0;
      end else begin
         bmap <= bmap_nxt;
         pset <= set_hit;
         pclr <= clr_hit && !set_hit && (bmap_nxt == '0);
      end
   end
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
   import sgi_pkg::*;
#(
   parameter int N_CPU = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     trig_we,
   input  logic [31:0]              trig_data,
   input  logic [CPU_W-1:0]         wr_cpu,
   input  logic                     src_we,
   input  logic                     src_set,
   input  logic [SGI_IDX_W-1:0]     src_id,
   input  logic [7:0]               src_data,
   output logic [7:0]               src_rdata,
   input  logic [N_CPU-1:0]         ack_req,
   input  logic [N_CPU*ID_W-1:0]    ack_id,
   output logic [N_CPU-1:0]         ack_vld,
   output logic [N_CPU*ACK_W-1:0]   ack_val,
   output logic [N_CPU*SGI_NUM-1:0] pend_set,
   output logic [N_CPU*SGI_NUM-1:0] pend_clr
);
   localparam int MAP_BITS = N_CPU * SGI_NUM * N_CPU;
   localparam int IDX_W    = (N_CPU > 1) ? $clog2(N_CPU) : 1;

   if (N_CPU < 1 || N_CPU > MAX_CPU) begin : g_bad_ncpu
      $error("sgi_dispatch: N_CPU must be within 1..8");
   end

   logic [MAP_BITS-1:0]  bmap_flat;
   logic [N_CPU-1:0]     wr_oh;
   logic [N_CPU-1:0]     tmask;
   logic [ID_W-1:0]      trig_id;
   logic                 trig_ok;
   logic [N_CPU-1:0]     src_bits;
   logic                 unused_bits;

   assign trig_id     = trig_data[ID_W-1:0];
   assign trig_ok     = trig_we && (trig_id < ID_W'(SGI_NUM));
   assign src_bits    = src_data[N_CPU-1:0];
   assign unused_bits = ^{trig_data[31:26], trig_data[15:ID_W], src_data};

   for (genvar c = 0; c < N_CPU; c++) begin : g_wr_oh
      assign wr_oh[c] = (wr_cpu == CPU_W'(c));
   end

   sgi_target_decode #(.N_CPU(N_CPU)) u_tdec (
      .flt   (trig_data[25:24]),
      .list  (trig_data[23:16]),
      .wr_oh (wr_oh),
      .tmask (tmask)
   );

   for (genvar t = 0; t < N_CPU; t++) begin : g_tgt
      logic [ID_W-1:0]  aid;
      logic             aok;
      logic [N_CPU-1:0] sel_map;
      logic [N_CPU-1:0] sel_oh;
      logic [IDX_W-1:0] sel_idx;
      logic             sel_any;
      logic [SRC_W-1:0] src_code;

      assign aid     = ack_id[t*ID_W +: ID_W];
      assign aok     = ack_req[t] && (aid < ID_W'(SGI_NUM));
      assign sel_map = bmap_flat[(t*SGI_NUM + int'(aid[SGI_IDX_W-1:0]))*N_CPU +: N_CPU];

      sgi_first_set #(.W(N_CPU)) u_first (
         .vec    (sel_map),
         .onehot (sel_oh),
         .idx    (sel_idx),
         .any    (sel_any)
      );

      assign src_code = aok ? SRC_W'(sel_idx) : '0;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ack_vld[t]              <= 1'b0;
            ack_val[t*ACK_W +: ACK_W] <= '0;
         end else begin
            ack_vld[t] <= ack_req[t];
            if (ack_req[t]) ack_val[t*ACK_W +: ACK_W] <= {src_code, aid};
         end
      end

      for (genvar i = 0; i < SGI_NUM; i++) begin : g_id
         logic             trig_hit;
         logic             byte_hit;
         logic             ack_hit;
         logic             set_hit;
         logic             clr_hit;
         logic [N_CPU-1:0] set_bits;
         logic [N_CPU-1:0] clr_bits;

         assign trig_hit = trig_ok && tmask[t] && (trig_id[SGI_IDX_W-1:0] == SGI_IDX_W'(i));
         assign byte_hit = src_we && wr_oh[t] && (src_id == SGI_IDX_W'(i));
         assign ack_hit  = aok && sel_any && (aid[SGI_IDX_W-1:0] == SGI_IDX_W'(i));
         assign set_hit  = trig_hit || (byte_hit && src_set);
         assign clr_hit  = ack_hit || (byte_hit && !src_set);
         assign set_bits = (trig_hit ? wr_oh : '0) | ((byte_hit && src_set) ? src_bits : '0);
         assign clr_bits = (ack_hit ? sel_oh : '0) | ((byte_hit && !src_set) ? src_bits : '0);

         sgi_src_cell #(.N_CPU(N_CPU)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_bits),
            .set_hit  (set_hit),
            .clr_bits (clr_bits),
            .clr_hit  (clr_hit),
            .bmap     (bmap_flat[(t*SGI_NUM + i)*N_CPU +: N_CPU]),
            .pset     (pend_set[t*SGI_NUM + i]),
            .pclr     (pend_clr[t*SGI_NUM + i])
         );
      end
   end

   always_comb begin
      src_rdata = '0;
      if (int'(wr_cpu) < N_CPU)
         src_rdata[N_CPU-1:0] = bmap_flat[(int'(wr_cpu)*SGI_NUM + int'(src_id))*N_CPU +: N_CPU];
   end
endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
   import sgi_pkg::*;
#(
   parameter int N_CPU = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     trig_we,
   input logic [ID_W-1:0]          trig_id,
   input logic [1:0]               trig_flt,
   input logic [CPU_W-1:0]         wr_cpu,
   input logic                     src_we,
   input logic                     src_set,
   input logic [N_CPU-1:0]         ack_req,
   input logic [N_CPU*ID_W-1:0]    ack_id,
   input logic [N_CPU-1:0]         ack_vld,
   input logic [N_CPU*ACK_W-1:0]   ack_val,
   input logic [N_CPU*SGI_NUM-1:0] pend_set
);
   // R1: a dropped trigger number raises nothing
   p_big_id_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_we && trig_id >= ID_W'(SGI_NUM) && !src_we) |=> (pend_set == '0));

   // R3: rule 2 reaches exactly one target
   p_self_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_we && trig_flt == 2'd2 && trig_id < ID_W'(SGI_NUM) && !src_we
       && int'(wr_cpu) < N_CPU) |=> ($countones(pend_set) == 1));

   // R3: rule 1 reaches all but the writer
   p_others_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_we && trig_flt == 2'd1 && trig_id < ID_W'(SGI_NUM) && !src_we
       && int'(wr_cpu) < N_CPU) |=> ($countones(pend_set) == N_CPU - 1));

   // R8: set byte write raises exactly the writer's bit
   p_byte_set_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (src_we && src_set && !trig_we && int'(wr_cpu) < N_CPU)
      |=> ($countones(pend_set) == 1));

   for (genvar t = 0; t < N_CPU; t++) begin : g_ack
      // R5: acknowledge result follows request by one cycle
      p_ack_vld_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ack_req[t] |=> ack_vld[t]);
      p_ack_vld_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
         !ack_req[t] |=> !ack_vld[t]);
      // R5: number field echoes the request
      p_ack_id_echo_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ack_req[t] |=> (ack_val[t*ACK_W +: ID_W] == $past(ack_id[t*ID_W +: ID_W])));
      // R5: reported source is an implemented CPU
      p_ack_src_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ack_vld[t] |-> (int'(ack_val[t*ACK_W + ID_W +: SRC_W]) < N_CPU));
   end
endmodule

bind sgi_dispatch sgi_dispatch_chk #(.N_CPU(N_CPU)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .trig_we  (trig_we),
   .trig_id  (trig_data[9:0]),
   .trig_flt (trig_data[25:24]),
   .wr_cpu   (wr_cpu),
   .src_we   (src_we),
   .src_set  (src_set),
   .ack_req  (ack_req),
   .ack_id   (ack_id),
   .ack_vld  (ack_vld),
   .ack_val  (ack_val),
   .pend_set (pend_set)
);

// File: tb/test_sgi_dispatch.sv
`timescale 1ns/1ps
module test_sgi_dispatch;
   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          trig_we = 1'b0;
   logic [31:0]   trig_data = '0;
   logic [2:0]    wr_cpu = '0;
   logic          src_we = 1'b0;
   logic          src_set = 1'b0;
   logic [3:0]    src_id = '0;
   logic [7:0]    src_data = '0;
   logic [7:0]    src_rdata;
   logic [N-1:0]  ack_req = '0;
   logic [N*10-1:0] ack_id = '0;
   logic [N-1:0]  ack_vld;
   logic [N*13-1:0] ack_val;
   logic [N*16-1:0] pend_set;
   logic [N*16-1:0] pend_clr;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   sgi_dispatch #(.N_CPU(N)) i_sgi_dispatch (
      .clk(clk), .rst_n(rst_n), .trig_we(trig_we), .trig_data(trig_data),
      .wr_cpu(wr_cpu), .src_we(src_we), .src_set(src_set), .src_id(src_id),
      .src_data(src_data), .src_rdata(src_rdata), .ack_req(ack_req),
      .ack_id(ack_id), .ack_vld(ack_vld), .ack_val(ack_val),
      .pend_set(pend_set), .pend_clr(pend_clr)
   );

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] b(int t, int id);
      return 64'd1 << (t*16 + id);
   endfunction

   task automatic trig(int w, int flt, int list, int id);
      @(negedge clk);
      wr_cpu = 3'(w);
      trig_data = (32'(flt) << 24) | (32'(list) << 16) | 32'(id);
      trig_we = 1'b1;
      @(negedge clk);
      trig_we = 1'b0;
   endtask

   task automatic src_wr(int w, int id, bit set, int data);
      @(negedge clk);
      wr_cpu = 3'(w); src_id = 4'(id); src_set = set; src_data = 8'(data);
      src_we = 1'b1;
      @(negedge clk);
      src_we = 1'b0;
   endtask

   task automatic ack(int t, int id);
      @(negedge clk);
      ack_id[t*10 +: 10] = 10'(id);
      ack_req[t] = 1'b1;
      @(negedge clk);
      ack_req[t] = 1'b0;
   endtask

   function automatic logic [63:0] rd(int w, int id);
      return 64'(0);
   endfunction

   task automatic peek(string req, int w, int id, int exp);
      wr_cpu = 3'(w); src_id = 4'(id);
      #1;
      chk(req, 64'(src_rdata), 64'(exp));
   endtask

   task automatic t_reset();
      chk("R11 pend_set", pend_set, '0);
      chk("R11 pend_clr", pend_clr, '0);
      chk("R11 ack_vld", 64'(ack_vld), '0);
      chk("R11 ack_val", 64'(ack_val), '0);
      peek("R11 bitmap", 2, 3, 0);
   endtask

   task automatic t_list();
      trig(1, 0, 8'h45, 3);  // R2: bit 22 is beyond N and is dropped
      chk("R2 list targets", pend_set, b(0,3) | b(2,3));
      peek("R4 bitmap t0", 0, 3, 8'h02);
      peek("R4 bitmap t2", 2, 3, 8'h02);
   endtask

   task automatic t_rules();
      trig(2, 1, 0, 5);
      chk("R3 rule1", pend_set, b(0,5) | b(1,5) | b(3,5));
      trig(3, 2, 0, 7);
      chk("R3 rule2", pend_set, b(3,7));
      trig(0, 3, 0, 9);
      chk("R3 rule3", pend_set, b(0,9) | b(1,9) | b(2,9) | b(3,9));
      chk("R4 pulse one cycle", pend_clr, '0);
      @(negedge clk);
      chk("R4 pulse ends", pend_set, '0);
   endtask

   task automatic t_ack();
      trig(3, 0, 8'h01, 4);
      trig(1, 0, 8'h01, 4);
      peek("R4 two sources", 0, 4, 8'h0A);
      ack(0, 4);
      chk("R5 lowest src", 64'(ack_val[12:0]), 64'h404);
      chk("R5 vld", 64'(ack_vld), 64'h1);
      chk("R6 not empty", pend_clr, '0);
      peek("R5 one bit cleared", 0, 4, 8'h08);
      ack(0, 4);
      chk("R5 next src", 64'(ack_val[12:0]), 64'hC04);
      chk("R6 empty", pend_clr, b(0,4));
      ack(3, 9);
      chk("R5 src0", 64'(ack_val[3*13 +: 13]), 64'h009);
      chk("R6 empty t3", pend_clr, b(3,9));
   endtask

   task automatic t_bytes();
      src_wr(2, 6, 1'b1, 8'h0B);
      chk("R8 set pulse", pend_set, b(2,6));
      peek("R8 bits", 2, 6, 8'h0B);
      src_wr(2, 6, 1'b0, 8'h03);
      chk("R7 partial clr", pend_clr, '0);
      peek("R7 bits", 2, 6, 8'h08);
      src_wr(2, 6, 1'b0, 8'h08);
      chk("R7 final clr", pend_clr, b(2,6));
      peek("R9 empty", 2, 6, 0);
      src_wr(1, 10, 1'b1, 8'h00);
      chk("R8 zero data pends", pend_set, b(1,10));
   endtask

   task automatic t_ignored();
      trig(0, 3, 0, 20);
      chk("R1 big id", pend_set, '0);
      peek("R1 no bitmap", 0, 4, 0);
      ack(1, 10);
      chk("R10 empty ack", 64'(ack_val[13 +: 13]), 64'h00A);
      chk("R10 no clr", pend_clr, '0);
      ack(2, 300);
      chk("R10 big ack", 64'(ack_val[26 +: 13]), 64'h12C);
      chk("R10 no clr big", pend_clr, '0);
      peek("R10 bitmap kept", 2, 3, 8'h02);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_list();
      t_rules();
      t_ack();
      t_bytes();
      t_ignored();
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule